// File: doc/BRIEF.md
# UART Interrupt Cause Arbiter

This block holds the interrupt causes of a FIFO-less serial port and turns them into one interrupt line and an 8-bit identification code. Four single-cycle event pulses come from the surrounding port logic: a receive line error, a received byte, a transmit holding register that has become empty, and a change on the modem inputs. Each pulse sets a waiting flag for its cause, whether or not that cause is enabled.

A 4-bit enable word selects which waiting causes may interrupt. The enabled cause with the highest priority sets the identification code, and the interrupt line is raised whenever any enabled cause is waiting. Each cause is cleared by the register access that services it, and not by a shared acknowledge. The bus decoder turns those accesses into single-cycle strobes. Clearing one cause lets the next enabled waiting cause show on the following edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification code is 0x01, the interrupt line is low, and no cause is waiting.
- R2: An event pulse sets its cause's waiting flag even when the cause is disabled. Enable bits are: bit0 received data, bit1 transmit holding empty, bit2 line error, bit3 modem change.
- R3: Among the enabled waiting causes, the line error wins, then received data, then transmit empty, then modem change.
- R4: The code is 0x06 for a line error, 0x04 for received data, 0x02 for transmit empty and 0x00 for a modem change. Bits 7..3 are always zero.
- R5: When no enabled cause is waiting, the code is 0x01.
- R6: A line status read clears the line error cause. A receive buffer read clears the received data cause.
- R7: The transmit empty cause is cleared by a transmit holding write. An identification read also clears it, but only in a cycle where the code being shown is 0x02. An identification read at any other time leaves it waiting.
- R8: A modem status read clears the modem change cause.
- R9: The code is updated at the clock edge that samples an event, a clear or an enable change. Clearing an enable bit hides its cause but keeps it waiting.
- R10: When an event pulse and its clear strobe arrive in the same cycle, the cause stays waiting.
- R11: The interrupt line is high exactly when the code is not 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_line_err | input | 1 | Receive line error event pulse |
| ev_rx_avail | input | 1 | Received byte event pulse |
| ev_tx_empty | input | 1 | Transmit holding empty event pulse |
| ev_modem_chg | input | 1 | Modem input change event pulse |
| ier | input | 4 | Cause enable word |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_iir | input | 1 | Identification register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| iir_o | output | 8 | Interrupt identification code |
| irq_o | output | 1 | Interrupt request line |

## Verification
Each cause's waiting flag is internal state, so it is checked at the ports by changing the enable word or clearing the causes above it. A flag that was lost or left set shows up as a wrong code on the edge right after that step. The checks that a cause stays waiting mix disabled causes, identification reads at the wrong time, and an event that arrives with its own clear strobe. In each case the cause must come back as soon as it is enabled again or becomes the highest priority. A fault in the priority order or the code values shows up on the first cycle in which two causes are waiting together.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_line_err,
  input  logic       ev_rx_avail,
  input  logic       ev_tx_empty,
  input  logic       ev_modem_chg,
  input  logic [3:0] ier,
  input  logic       rd_lsr,
  input  logic       rd_rbr,
  input  logic       rd_iir,
  input  logic       wr_thr,
  input  logic       rd_msr,
  output logic [7:0] iir_o,
  output logic       irq_o
);

  localparam logic [7:0] CODE_NONE  = 8'h01;
  localparam logic [7:0] CODE_LINE  = 8'h06;
  localparam logic [7:0] CODE_RX    = 8'h04;
  localparam logic [7:0] CODE_TX    = 8'h02;
  localparam logic [7:0] CODE_MODEM = 8'h00;

  // waiting flags, indexed like the enable word
  logic [3:0] wait_q, wait_d, live;
  logic [7:0] code_q, code_d;
  logic       tx_ack;

  assign tx_ack = wr_thr | (rd_iir & (code_q == CODE_TX));

  assign wait_d[0] = ev_rx_avail  | (wait_q[0] & ~rd_rbr);
  assign wait_d[1] = ev_tx_empty  | (wait_q[1] & ~tx_ack);
  assign wait_d[2] = ev_line_err  | (wait_q[2] & ~rd_lsr);
  assign wait_d[3] = ev_modem_chg | (wait_q[3] & ~rd_msr);

  assign live = wait_d & ier;

  always_comb begin
    if (live[2])      code_d = CODE_LINE;
    else if (live[0]) code_d = CODE_RX;
    else if (live[1]) code_d = CODE_TX;
    else if (live[3]) code_d = CODE_MODEM;
    else              code_d = CODE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= '0;
      code_q <= CODE_NONE;
    end else begin
      wait_q <= wait_d;
      code_q <= code_d;
    end
  end

  assign iir_o = code_q;
  assign irq_o = (code_q != CODE_NONE);

endmodule

module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_line_err,
  input logic       ev_rx_avail,
  input logic       ev_tx_empty,
  input logic       ev_modem_chg,
  input logic [3:0] ier,
  input logic       wr_thr,
  input logic       rd_msr,
  input logic [7:0] iir_o,
  input logic       irq_o
);

  a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_o == 8'h01 || iir_o == 8'h00 || iir_o == 8'h02 || iir_o == 8'h04 || iir_o == 8'h06));

  a_r3_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_line_err && ier[2]) |=> (iir_o == 8'h06 && irq_o));

  a_r2_rx_report: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_avail && ier == 4'b0001) |=> (iir_o == 8'h04));

  a_r5_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'b0000) |=> (iir_o == 8'h01 && !irq_o));

  a_r7_thr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && !ev_tx_empty && ier == 4'b0010) |=> !irq_o);

  a_r8_msr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && !ev_modem_chg && ier == 4'b1000) |=> !irq_o);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_line_err(ev_line_err), .ev_rx_avail(ev_rx_avail),
  .ev_tx_empty(ev_tx_empty), .ev_modem_chg(ev_modem_chg),
  .ier(ier), .wr_thr(wr_thr), .rd_msr(rd_msr),
  .iir_o(iir_o), .irq_o(irq_o)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_line_err = 0, ev_rx_avail = 0, ev_tx_empty = 0, ev_modem_chg = 0;
  logic [3:0] ier = '0;
  logic rd_lsr = 0, rd_rbr = 0, rd_iir = 0, wr_thr = 0, rd_msr = 0;
  logic [7:0] iir_o;
  logic irq_o;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n),
    .ev_line_err(ev_line_err), .ev_rx_avail(ev_rx_avail),
    .ev_tx_empty(ev_tx_empty), .ev_modem_chg(ev_modem_chg),
    .ier(ier), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_iir(rd_iir),
    .wr_thr(wr_thr), .rd_msr(rd_msr), .iir_o(iir_o), .irq_o(irq_o)
  );

  // {ev[3:0] = modem,line,tx,rx ; clr[4:0] = msr,thr,iir,rbr,lsr ; ier ; expected code}
  localparam int NV = 31;
  localparam logic [20:0] VEC [NV] = '{
    {4'b0000, 5'b00000, 4'h0, 8'h01},  // R5
    {4'b0001, 5'b00000, 4'h0, 8'h01},  // R2 latched while disabled
    {4'b0000, 5'b00000, 4'h1, 8'h04},  // R9 R2
    {4'b0100, 5'b00000, 4'h1, 8'h04},  // R2 line hidden
    {4'b0000, 5'b00000, 4'h5, 8'h06},  // R3 R4
    {4'b0000, 5'b00001, 4'h5, 8'h04},  // R6 lsr read
    {4'b0010, 5'b00000, 4'h7, 8'h04},  // R3
    {4'b0000, 5'b00010, 4'h7, 8'h02},  // R6 rbr read
    {4'b1000, 5'b00000, 4'hF, 8'h02},  // R3
    {4'b0000, 5'b00100, 4'hF, 8'h00},  // R7 iir read while 0x02
    {4'b0000, 5'b10000, 4'hF, 8'h01},  // R8
    {4'b0010, 5'b00000, 4'hF, 8'h02},  // R4
    {4'b0000, 5'b01000, 4'hF, 8'h01},  // R7 thr write
    {4'b1000, 5'b00000, 4'h7, 8'h01},  // R2 modem hidden
    {4'b0010, 5'b00100, 4'hF, 8'h02},  // R7 iir read at 0x01 no effect
    {4'b0000, 5'b00100, 4'hF, 8'h00},  // R7
    {4'b0000, 5'b10000, 4'hF, 8'h01},  // R8
    {4'b0001, 5'b00010, 4'hF, 8'h04},  // R10 set wins
    {4'b0000, 5'b00010, 4'hF, 8'h01},  // R6
    {4'b1111, 5'b00000, 4'hF, 8'h06},  // R3 all four
    {4'b0000, 5'b00001, 4'hF, 8'h04},  // R3
    {4'b0000, 5'b00010, 4'hF, 8'h02},  // R3
    {4'b0000, 5'b00100, 4'hF, 8'h00},  // R3 R7
    {4'b0000, 5'b10000, 4'hF, 8'h01},  // R8
    {4'b0011, 5'b00000, 4'hF, 8'h04},  // R3
    {4'b0000, 5'b00100, 4'hF, 8'h04},  // R7 iir read at 0x04 keeps tx
    {4'b0000, 5'b00010, 4'hF, 8'h02},  // R7
    {4'b0000, 5'b01000, 4'hF, 8'h01},  // R7
    {4'b0100, 5'b00000, 4'h0, 8'h01},  // R2
    {4'b0000, 5'b00000, 4'h4, 8'h06},  // R9
    {4'b0000, 5'b00001, 4'h4, 8'h01}   // R6
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] ev, input logic [4:0] cl, input logic [3:0] en);
    {ev_modem_chg, ev_line_err, ev_tx_empty, ev_rx_avail} = ev;
    {rd_msr, wr_thr, rd_iir, rd_rbr, rd_lsr} = cl;
    ier = en;
    @(posedge clk);
    #2;
    {ev_modem_chg, ev_line_err, ev_tx_empty, ev_rx_avail} = '0;
    {rd_msr, wr_thr, rd_iir, rd_rbr, rd_lsr} = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset code", iir_o, 8'h01);
    chk("R1 reset irq", {7'b0, irq_o}, 8'h00);
    rst_n = 1'b1;
    apply(4'b0000, 5'b00000, 4'hF);
    chk("R1 nothing waiting", iir_o, 8'h01);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][20:17], VEC[i][16:12], VEC[i][11:8]);
      chk($sformatf("R3 R4 R11 vec %0d code", i), iir_o, VEC[i][7:0]);
      chk($sformatf("R11 vec %0d irq", i), {7'b0, irq_o}, {7'b0, VEC[i][7:0] != 8'h01});
    end

    // R9: disabling hides but keeps waiting
    apply(4'b0001, 5'b00000, 4'h1);
    chk("R9 rx shown", iir_o, 8'h04);
    apply(4'b0000, 5'b00000, 4'h0);
    chk("R9 hidden", iir_o, 8'h01);
    apply(4'b0000, 5'b00000, 4'h1);
    chk("R9 re-enabled", iir_o, 8'h04);

    // R10 for line error and modem change
    apply(4'b1100, 5'b10001, 4'hC);
    chk("R10 line kept", iir_o, 8'h06);
    apply(4'b0000, 5'b00001, 4'hC);
    chk("R10 modem kept", iir_o, 8'h00);

    // R1: reset drops waiting causes
    rst_n = 1'b0;
    apply(4'b0000, 5'b00000, 4'hF);
    chk("R1 code in reset", iir_o, 8'h01);
    rst_n = 1'b1;
    apply(4'b0000, 5'b00000, 4'hF);
    chk("R1 causes dropped", iir_o, 8'h01);
    chk("R1 irq low", {7'b0, irq_o}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule